// File: doc/BRIEF.md
# Bit-Serial Signed Multiplier with Column Ones-Counters

This block multiplies two N-bit two's-complement operands that arrive one bit per clock on two wires. The X operand enters most significant bit first and the Y operand enters least significant bit first. Because of this opposite ordering, every partial-product bit of the N×N matrix can be formed within the N input cycles. In each cycle at most one new bit lands in each weight column. One small ones-counter per column accumulates these bits.

The sign rows follow the Baugh-Wooley form. A partial-product bit that pairs exactly one sign bit with a non-sign bit enters as its inverted AND. The X sign bit is latched in the first cycle and reused while later Y bits arrive. The Y sign bit is only present in the last input cycle, so the bits that depend on it form there. The two fixed correction ones, at weights 2^N and 2^(2N-1), are added as a constant row. This happens in the carry-save reduction that turns the counter values into the 2N-bit product.

The serial input stream has no back-pressure. A `start` pulse plays the part of a valid strobe for the first bit pair, and the block accepts one bit of each operand on every following cycle without stalling. The result side is a registered product with a one-cycle `done` strobe. The consumer must take it when `done` is high.

Top module: `sbw_serial_mult`

## Requirements
- R1: `start` high marks the cycle that carries x[N-1] on `x_in` and y[0] on `y_in`. In the N-1 cycles after it, `x_in` carries x[N-2] down to x[0] and `y_in` carries y[1] up to y[N-1], one bit each per cycle, and every bit is taken.
- R2: `product` equals the 2N-bit two's-complement product of X and Y for every operand pair. This includes (-2^(N-1))·(-2^(N-1)) = 2^(2N-2), which is 16'h4000 for N=8.
- R3: `done` is high for exactly one cycle. It rises on the N-th rising clock edge after the edge that sampled `start`, which is one edge after the last operand bits are sampled.
- R4: `product` changes only on the edge that raises `done` and holds its value at all other times.
- R5: a `start` that arrives while an operation is still taking bits abandons that operation. The abandoned operation gives no `done` and no product, and the new operation runs normally.
- R6: a `start` in the cycle right after the last bit of an operation is accepted. Operations can therefore run back to back, one every N cycles, and each result is correct.
- R7: with no operation running and `start` low, `x_in` and `y_in` are ignored. No `done` appears and `product` is unchanged.
- R8: while `rst_n` is low, `done` is 0 and `product` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Marks the first bit pair of an operation |
| x_in | input | 1 | Serial X operand, most significant bit first |
| y_in | input | 1 | Serial Y operand, least significant bit first |
| product | output | 2N | Registered signed product |
| done | output | 1 | One-cycle strobe, high when a new product is present |

## Verification
A result is due on the N-th rising edge after the `start` edge. A back-to-back operation therefore has its `start` on the same edge that delivers the previous result. When the driver issues an operation, it records the cycle number at which `done` must appear, next to the expected product. The monitor samples shortly after each rising edge and pops an entry only when `done` is high. It compares both the value and the cycle count, so an early, late or extra strobe is caught. Abandoned operations push no entry, and idle stretches check that the held product and the strobe count stay unchanged.

// File: rtl/sbw_pkg.sv
package sbw_pkg;

  // Operation phase of the serial multiplier
  typedef enum logic [1:0] {
    SBW_IDLE    = 2'd0,
    SBW_COLLECT = 2'd1,
    SBW_RESULT  = 2'd2
  } sbw_phase_e;

endpackage

// File: rtl/sbw_ppgen.sv
// Forms, for the current input step, the one partial-product bit that
// lands in each weight column (at most one per column per step).
module sbw_ppgen #(
  parameter int N    = 8,
  parameter int RW   = $clog2(N),
  parameter int NCOL = 2*N-1
) (
  input  logic [RW-1:0]   step,
  input  logic            x_in,
  input  logic            y_in,
  input  logic [N-2:0]    x_hist,   // x_hist[k] = X bit taken at step k (k=0: sign)
  input  logic [N-2:0]    y_hist,   // y_hist[k] = y[k]
  output logic [NCOL-1:0] col_bit
);

  int   st;
  logic first_step;
  logic last_step;

  assign st         = {{(32-RW){1'b0}}, step};
  assign first_step = (step == '0);
  assign last_step  = (step == RW'(N-1));

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    logic b;
    if (c == N-1) begin : g_center
      // x[N-1-r]*y[r]: one operand is a sign bit on the first and last step
      assign b = (x_in & y_in) ^ (first_step ^ last_step);
    end else if (c < N-1) begin : g_low
      // new X bit against earlier Y bits: never involves a sign bit here
      always_comb begin
        b = 1'b0;
        for (int k = 0; k < N-1; k++)
          if (k < st && k == c - (N-1) + st) b = x_in & y_hist[k];
      end
    end else begin : g_high
      // new Y bit against earlier X bits; invert when exactly one is a sign bit
      always_comb begin
        b = 1'b0;
        for (int k = 0; k < N-1; k++)
          if (k < st && k == (N-1) + st - c)
            b = (y_in & x_hist[k]) ^ ((k == 0) ^ last_step);
      end
    end
    assign col_bit[c] = b;
  end

endmodule

// File: rtl/sbw_colcount.sv
// One ones-counter per weight column.
module sbw_colcount #(
  parameter int NCOL = 15,
  parameter int CW   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,    // load with this step's bit
  input  logic              enable,   // add this step's bit
  input  logic [NCOL-1:0]   col_bit,
  output logic [NCOL*CW-1:0] counts
);

  for (genvar c = 0; c < NCOL; c++) begin : g_cnt
    logic [CW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= '0;
      else if (clear)  q <= CW'(col_bit[c]);
      else if (enable) q <= q + CW'(col_bit[c]);
    end
    assign counts[c*CW +: CW] = q;
  end

endmodule

// File: rtl/sbw_csa_reduce.sv
// Lays the counter bits out as CW shifted rows plus a constant row,
// compresses them with 3:2 carry-save steps, then adds the last two rows.
module sbw_csa_reduce #(
  parameter int N    = 8,
  parameter int CW   = 4,
  parameter int NCOL = 2*N-1,
  parameter int PW   = 2*N
) (
  input  logic [NCOL*CW-1:0] counts,
  output logic [PW-1:0]      sum
);

  localparam logic [PW-1:0] FIX_ROW = (PW'(1) << N) | (PW'(1) << (PW-1));

  logic [PW-1:0] s, cy, row, t;

  always_comb begin
    s  = '0;
    cy = '0;
    for (int b = 0; b <= CW; b++) begin
      row = '0;
      if (b == CW) row = FIX_ROW;
      else
        for (int c = 0; c < NCOL; c++)
          if (c + b < PW && counts[c*CW + b]) row[c + b] = 1'b1;
      t  = s ^ cy ^ row;
      cy = ((s & cy) | (s & row) | (cy & row)) << 1;
      s  = t;
    end
    sum = s + cy;
  end

endmodule

// File: rtl/sbw_serial_mult.sv
module sbw_serial_mult #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           x_in,
  input  logic           y_in,
  output logic [2*N-1:0] product,
  output logic           done
);
  import sbw_pkg::*;

  localparam int RW   = $clog2(N);
  localparam int CW   = $clog2(N+1);
  localparam int NCOL = 2*N-1;
  localparam int PW   = 2*N;

  sbw_phase_e          phase;
  logic [RW-1:0]       cnt;
  logic [RW-1:0]       step;
  logic [N-2:0]        x_hist;
  logic [N-2:0]        y_hist;
  logic [NCOL-1:0]     col_bit;
  logic [NCOL*CW-1:0]  counts;
  logic [PW-1:0]       reduced;
  logic                collecting;

  assign step       = start ? '0 : cnt;
  assign collecting = (phase == SBW_COLLECT) && !start;

  sbw_ppgen #(.N(N), .RW(RW), .NCOL(NCOL)) u_ppgen (
    .step    (step),
    .x_in    (x_in),
    .y_in    (y_in),
    .x_hist  (x_hist),
    .y_hist  (y_hist),
    .col_bit (col_bit)
  );

  sbw_colcount #(.NCOL(NCOL), .CW(CW)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (start),
    .enable  (collecting),
    .col_bit (col_bit),
    .counts  (counts)
  );

  sbw_csa_reduce #(.N(N), .CW(CW), .NCOL(NCOL), .PW(PW)) u_reduce (
    .counts (counts),
    .sum    (reduced)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= SBW_IDLE;
      cnt     <= '0;
      x_hist  <= '0;
      y_hist  <= '0;
      product <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (phase == SBW_RESULT) begin
        product <= reduced;
        done    <= 1'b1;
      end
      if (start) begin
        x_hist[0] <= x_in;       // latched X sign bit
        y_hist[0] <= y_in;
        cnt       <= RW'(1);
        phase     <= SBW_COLLECT;
      end else begin
        unique case (phase)
          SBW_COLLECT: begin
            for (int k = 1; k < N-1; k++)
              if (cnt == RW'(k)) begin
                x_hist[k] <= x_in;
                y_hist[k] <= y_in;
              end
            if (cnt == RW'(N-1)) phase <= SBW_RESULT;
            else                 cnt   <= cnt + RW'(1);
          end
          SBW_RESULT: phase <= SBW_IDLE;
          default:    phase <= SBW_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/sbw_serial_mult_chk.sv
module sbw_serial_mult_chk #(
  parameter int N = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           x_in,
  input logic           y_in,
  input logic [2*N-1:0] product,
  input logic           done
);

  localparam int AW = $clog2(N+1);

  logic [AW-1:0]          age;
  logic                   started;
  logic [N-1:0]           xs, ys;
  logic signed [2*N-1:0]  expect_w;
  logic                   due_now;

  assign expect_w = $signed({{N{xs[N-1]}}, xs}) * $signed({{N{ys[N-1]}}, ys});
  assign due_now  = started && (age == AW'(N-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age <= '0; started <= 1'b0; xs <= '0; ys <= '0;
    end else if (start) begin
      age <= '0; started <= 1'b1;
      xs[N-1] <= x_in; ys[0] <= y_in;
    end else begin
      if (age != AW'(N)) age <= age + AW'(1);
      for (int k = 0; k < N-1; k++)
        if (age == AW'(k)) begin
          xs[N-2-k] <= x_in;
          ys[k+1]   <= y_in;
        end
    end
  end

  // R2: value delivered equals the signed product of the bits seen at the pins
  a_r2_signed_product: assert property (@(posedge clk) disable iff (!rst_n)
    due_now |=> (product == $past(expect_w)));

  // R3: strobe on the N-th edge after start
  a_r3_done_on_time: assert property (@(posedge clk) disable iff (!rst_n)
    due_now |=> done);

  // R3: strobe lasts one cycle
  a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5 and R7: no strobe without a completed operation
  a_r5_no_stray_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(due_now));

  // R4: product only moves with the strobe
  a_r4_product_held: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(product));

endmodule

bind sbw_serial_mult sbw_serial_mult_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .x_in(x_in), .y_in(y_in),
  .product(product), .done(done)
);

// File: tb/sbw_serial_mult_tb_top.sv
`timescale 1ns/1ps
module sbw_serial_mult_tb_top;
  localparam int N  = 8;
  localparam int PW = 2*N;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          x_in = 1'b0;
  logic          y_in = 1'b0;
  logic [PW-1:0] product;
  logic          done;

  always #2.5 clk = ~clk;   // 200 MHz

  sbw_serial_mult #(.N(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .x_in(x_in), .y_in(y_in),
    .product(product), .done(done)
  );

  int      checks = 0;
  int      failures = 0;
  int      done_seen = 0;
  longint  cyc = 0;
  bit      finished = 0;
  bit      prev_done = 0;

  logic [PW-1:0] exp_q[$];
  longint        due_q[$];
  string         tag_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // monitor / scoreboard
  always @(posedge clk) begin
    #1;
    if (rst_n && done) begin
      done_seen++;
      check(!prev_done, "R3", "strobe longer than one cycle", 1, 0);
      if (exp_q.size() == 0) begin
        check(1'b0, "R5", "strobe with no pending operation", product, 0);
      end else begin
        logic [PW-1:0] e;
        longint d;
        string t;
        e = exp_q.pop_front();
        d = due_q.pop_front();
        t = tag_q.pop_front();
        check(product == e, t, "product value (R2)", product, e);
        check(cyc == d, "R3", "strobe cycle", cyc, d);
      end
    end
    prev_done = rst_n && done;
  end

  // driver: nbits < N issues a cut-short operation with no expected result
  task automatic run_op(input logic [N-1:0] a, input logic [N-1:0] b,
                        input int nbits, input string tag);
    longint due = 0;
    for (int r = 0; r < nbits; r++) begin
      @(negedge clk);
      if (r == 0) due = cyc + 1 + N;
      start = (r == 0);
      x_in  = a[N-1-r];
      y_in  = b[r];
    end
    if (nbits == N) begin
      exp_q.push_back({{N{a[N-1]}}, a} * {{N{b[N-1]}}, b});
      due_q.push_back(due);
      tag_q.push_back(tag);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      start = 1'b0;
      x_in  = i[0];
      y_in  = i[1] ^ i[0];
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=expired expected=completion");
      finish_run();
    end
  end

  initial begin
    logic [PW-1:0] held;
    int            seen0;

    repeat (3) @(negedge clk);
    check(done == 1'b0, "R8", "done in reset", done, 0);
    check(product == '0, "R8", "product in reset", product, 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    // R1: order of bits; asymmetric values expose a swapped order
    run_op(8'h80, 8'h01, N, "R1"); idle(3);
    run_op(8'h01, 8'h80, N, "R1"); idle(3);
    run_op(8'h03, 8'h05, N, "R1"); idle(3);
    // R2 corners
    run_op(8'h80, 8'h80, N, "R2"); idle(2);
    run_op(8'h80, 8'h7F, N, "R2"); idle(2);
    run_op(8'hFF, 8'hFF, N, "R2"); idle(2);
    run_op(8'h7F, 8'h7F, N, "R2"); idle(2);
    run_op(8'h00, 8'h80, N, "R2"); idle(N+3);

    // R5: cut an operation short with a new start
    run_op(8'h55, 8'h33, 3, "R5");
    run_op(8'hC3, 8'h5A, N, "R5");
    run_op(8'h12, 8'h34, N-1, "R5");
    run_op(8'h9B, 8'hE7, N, "R5");
    idle(N+3);
    check(exp_q.size() == 0, "R5", "results outstanding", exp_q.size(), 0);

    // R7 / R4: activity on the serial pins while idle
    held  = product;
    seen0 = done_seen;
    idle(25);
    check(done_seen == seen0, "R7", "strobes while idle", done_seen, seen0);
    check(product == held, "R4", "product while idle", product, held);

    // R6: back-to-back sweep, every X against 64 spread Y values
    for (int xv = 0; xv < (1 << N); xv++)
      for (int j = 0; j < 64; j++)
        run_op(N'(xv), N'(j*4 + (j % 4)), N, "R6");
    idle(N+4);
    check(exp_q.size() == 0, "R3", "results missing after sweep", exp_q.size(), 0);

    finish_run();
  end

endmodule